// File: doc/BRIEF.md
# Pseudo-Associative Read Cache

This block is a small read cache with direct-mapped placement whose line array is treated as two halves. A request first probes its home line. If that line does not hold the block, a second probe one cycle later looks at the partner line: the same index with its top bit inverted. A match in the partner is a slow hit. A match in neither place fetches the line from memory through a single-word refill port. A response therefore arrives after one of three latencies, fast < slow < miss. A kind code returned with every response lets performance counters tell them apart.

The array has one read port, so the two probes happen in sequence. After a slow hit the two lines trade places, so the block just used sits at its home index. After a refill the new block goes to its home index and the block it displaced moves to the partner slot. Each stored tag carries the index top bit as well as the upper address bits, so a block is still identified correctly when it lives in its partner slot. One request is in flight at a time. The block handles reads only.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and every line is empty, so the first access to any address is a miss.
- R2: A request whose home line (index = low `IDX_W` address bits) holds its block responds with `rsp_kind` = 1 (fast) and that block's data exactly one clock after the clock that accepted it.
- R3: The partner line is the home index with its most significant bit inverted. Stored tags include that bit. A match there responds with `rsp_kind` = 2 (slow) and the block's data two clocks after acceptance.
- R4: After a slow hit the home line and the partner line exchange contents, so an immediate repeat of the same address is a fast hit.
- R5: When both probes fail, `mem_req` rises two clocks after acceptance with `mem_addr` equal to the request address. It holds with a stable address until `mem_valid` is sampled. The response follows one clock after that sample, with `rsp_kind` = 3 (miss) and `mem_data` as data.
- R6: A refill writes the new block into its home line. A valid block previously at home moves to the partner line, and the partner's earlier block is dropped.
- R7: `req_ready` is 0 from the clock after acceptance until the response, and `rsp_valid` is a single-cycle pulse.
- R8: Fast and slow hits never raise `mem_req`.
- R9: `rsp_kind` is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Block idle, request taken this clock if offered |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DATA_W | Read data |
| rsp_kind | output | 2 | 0 none, 1 fast hit, 2 slow hit, 3 miss |
| mem_req | output | 1 | Refill request, held until served |
| mem_addr | output | ADDR_W | Refill word address |
| mem_valid | input | 1 | Refill data present |
| mem_data | input | DATA_W | Refill word |

## Verification
The bench targets addresses whose home index is another address's partner index. A design that left the index top bit out of the stored tag would report a false slow hit there and return the wrong word. It also repeats conflicting tags on one index pair. This catches a missing swap, which would turn the second repeat into another slow hit. It also catches a refill that fails to move the old home block, which would turn an expected slow hit into a miss. Refills that answer with no wait expose a design that responds before sampling `mem_valid` or that counts latency wrongly. The directed runs also include refills into an empty home line, so that a stale block is not copied into the partner slot.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_FAST = 2'd1,
        HIT_SLOW = 2'd2,
        HIT_MISS = 2'd3
    } hit_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRI  = 2'd1,
        ST_ALT  = 2'd2,
        ST_FILL = 2'd3
    } ctrl_state_e;

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
    parameter int IDX_W  = 4,
    parameter int TAGX_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAGX_W-1:0] rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic              wa_vld,
    input  logic [TAGX_W-1:0] wa_tag,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_vld,
    input  logic [TAGX_W-1:0] wb_tag,
    input  logic [DATA_W-1:0] wb_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  vld_d, vld_q;
    logic [TAGX_W-1:0] tag_d  [LINES];
    logic [TAGX_W-1:0] tag_q  [LINES];
    logic [DATA_W-1:0] data_d [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_comb begin
        vld_d  = vld_q;
        tag_d  = tag_q;
        data_d = data_q;
        if (wa_en) begin
            vld_d[wa_idx]  = wa_vld;
            tag_d[wa_idx]  = wa_tag;
            data_d[wa_idx] = wa_data;
        end
        if (wb_en) begin
            vld_d[wb_idx]  = wb_vld;
            tag_d[wb_idx]  = wb_tag;
            data_d[wb_idx] = wb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        data_q <= data_d;
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    // R4
    dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> (wa_idx != wb_idx));

endmodule

// File: rtl/pac_tag_match.sv
module pac_tag_match #(
    parameter int TAGX_W = 9
) (
    input  logic              line_vld,
    input  logic [TAGX_W-1:0] line_tag,
    input  logic [TAGX_W-1:0] probe_tag,
    output logic              hit
);
    assign hit = line_vld && (line_tag == probe_tag);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
    import pac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    localparam int TAGX_W = ADDR_W - IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_kind,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_vld,
    input  logic [TAGX_W-1:0] rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic [TAGX_W-1:0] probe_tag,
    input  logic              probe_hit,
    output logic              wa_en,
    output logic [IDX_W-1:0]  wa_idx,
    output logic              wa_vld,
    output logic [TAGX_W-1:0] wa_tag,
    output logic [DATA_W-1:0] wa_data,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic              wb_vld,
    output logic [TAGX_W-1:0] wb_tag,
    output logic [DATA_W-1:0] wb_data
);
    localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic              held_vld;
        logic [TAGX_W-1:0] held_tag;
        logic [DATA_W-1:0] held_data;
        logic              rsp_vld;
        hit_kind_e         kind;
        logic [DATA_W-1:0] rsp_data;
        logic              mem_req;
    } ctrl_t;

    ctrl_t d, q;

    logic [IDX_W-1:0] pri_idx, alt_idx;

    assign pri_idx   = q.addr[IDX_W-1:0];
    assign alt_idx   = pri_idx ^ FLIP;
    assign probe_tag = q.addr[ADDR_W-1:IDX_W-1];
    assign rd_idx    = (q.st == ST_ALT) ? alt_idx : pri_idx;

    always_comb begin
        d         = q;
        d.rsp_vld = 1'b0;
        d.kind    = HIT_NONE;
        wa_en   = 1'b0;
        wa_idx  = pri_idx;
        wa_vld  = 1'b0;
        wa_tag  = '0;
        wa_data = '0;
        wb_en   = 1'b0;
        wb_idx  = alt_idx;
        wb_vld  = 1'b0;
        wb_tag  = '0;
        wb_data = '0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.st   = ST_PRI;
                end
            end
            ST_PRI: begin
                if (probe_hit) begin
                    d.rsp_vld  = 1'b1;
                    d.kind     = HIT_FAST;
                    d.rsp_data = rd_data;
                    d.st       = ST_IDLE;
                end else begin
                    d.held_vld  = rd_vld;
                    d.held_tag  = rd_tag;
                    d.held_data = rd_data;
                    d.st        = ST_ALT;
                end
            end
            ST_ALT: begin
                if (probe_hit) begin
                    d.rsp_vld  = 1'b1;
                    d.kind     = HIT_SLOW;
                    d.rsp_data = rd_data;
                    d.st       = ST_IDLE;
                    wa_en   = 1'b1;
                    wa_vld  = 1'b1;
                    wa_tag  = rd_tag;
                    wa_data = rd_data;
                    wb_en   = 1'b1;
                    wb_vld  = q.held_vld;
                    wb_tag  = q.held_tag;
                    wb_data = q.held_data;
                end else begin
                    d.mem_req = 1'b1;
                    d.st      = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_valid) begin
                    wa_en   = 1'b1;
                    wa_vld  = 1'b1;
                    wa_tag  = probe_tag;
                    wa_data = mem_data;
                    wb_en   = q.held_vld;
                    wb_vld  = 1'b1;
                    wb_tag  = q.held_tag;
                    wb_data = q.held_data;
                    d.rsp_vld  = 1'b1;
                    d.kind     = HIT_MISS;
                    d.rsp_data = mem_data;
                    d.mem_req  = 1'b0;
                    d.st       = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_vld;
    assign rsp_data  = q.rsp_data;
    assign rsp_kind  = q.kind;
    assign mem_req   = q.mem_req;
    assign mem_addr  = q.addr;

    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    // R5
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R5
    miss_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == HIT_MISS) |-> $past(mem_valid));

    // R8
    no_mem_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == HIT_FAST || rsp_kind == HIT_SLOW)) |-> !mem_req);

    // R9
    kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_kind == HIT_NONE));

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_kind,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int TAGX_W = ADDR_W - IDX_W + 1;

    logic [IDX_W-1:0]  rd_idx;
    logic              rd_vld;
    logic [TAGX_W-1:0] rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic [TAGX_W-1:0] probe_tag;
    logic              probe_hit;
    logic              wa_en, wa_vld, wb_en, wb_vld;
    logic [IDX_W-1:0]  wa_idx, wb_idx;
    logic [TAGX_W-1:0] wa_tag, wb_tag;
    logic [DATA_W-1:0] wa_data, wb_data;

    pac_line_store #(.IDX_W(IDX_W), .TAGX_W(TAGX_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_data(rd_data),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_vld(wa_vld), .wa_tag(wa_tag), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data)
    );

    pac_tag_match #(.TAGX_W(TAGX_W)) u_match (
        .line_vld(rd_vld), .line_tag(rd_tag), .probe_tag(probe_tag), .hit(probe_hit)
    );

    pac_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_data(rd_data),
        .probe_tag(probe_tag), .probe_hit(probe_hit),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_vld(wa_vld), .wa_tag(wa_tag), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data)
    );

endmodule

// File: tb/sim_pseudo_assoc_cache.sv
`timescale 1ns/1ps
module sim_pseudo_assoc_cache;
    localparam int AW = 12;
    localparam int IW = 4;
    localparam int DW = 32;
    localparam int NL = 1 << IW;
    localparam int TW = AW - IW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, rsp_valid, mem_req;
    logic [DW-1:0] rsp_data;
    logic [1:0] rsp_kind;
    logic [AW-1:0] mem_addr;
    logic mem_valid = 1'b0;
    logic [DW-1:0] mem_data = '0;

    int n_run = 0;
    int n_fail = 0;

    logic          mv [NL];
    logic [TW-1:0] mt [NL];

    always #10 clk = ~clk;

    pseudo_assoc_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_kind(rsp_kind), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    function automatic logic [DW-1:0] memword(input logic [AW-1:0] a);
        return 32'hA500_0000 ^ ({20'd0, a} * 32'd2654435761);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input int lat);
        logic [IW-1:0] pri, alt;
        logic [TW-1:0] te;
        int ek, ecyc, cnt, waitc;
        bit saw_mem, addr_ok, busy_ok;
        pri = a[IW-1:0];
        alt = pri ^ IW'(1 << (IW - 1));
        te  = a[AW-1:IW-1];
        if (mv[pri] && mt[pri] == te) begin
            ek = 1; ecyc = 1;
        end else if (mv[alt] && mt[alt] == te) begin
            logic tv; logic [TW-1:0] tt;
            ek = 2; ecyc = 2;
            tv = mv[pri]; tt = mt[pri];
            mv[pri] = mv[alt]; mt[pri] = mt[alt];
            mv[alt] = tv; mt[alt] = tt;
        end else begin
            ek = 3; ecyc = 3 + lat;
            if (mv[pri]) begin mv[alt] = 1'b1; mt[alt] = mt[pri]; end
            mv[pri] = 1'b1; mt[pri] = te;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = !req_ready;
        cnt = 0; waitc = lat; saw_mem = 0; addr_ok = 1;
        while (!rsp_valid && cnt < 40) begin
            mem_valid = 1'b0;
            if (mem_req) begin
                saw_mem = 1;
                if (mem_addr !== a) addr_ok = 0;
                if (waitc == 0) begin
                    mem_valid = 1'b1;
                    mem_data  = memword(mem_addr);
                end else waitc--;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        mem_valid = 1'b0;
        // R7: busy right after acceptance
        chk(busy_ok, "R7", "req_ready while busy", 32'(req_ready), 32'd0);
        // R2 R3 R5: kind code and latency
        chk(rsp_valid && rsp_kind == 2'(ek), ek == 1 ? "R2" : (ek == 2 ? "R3" : "R5"),
            "rsp_kind", 32'(rsp_kind), 32'(ek));
        chk(cnt == ecyc, ek == 1 ? "R2" : (ek == 2 ? "R3" : "R5"),
            "latency", 32'(cnt), 32'(ecyc));
        // R4 R6: data correct wherever the line was placed
        chk(rsp_data == memword(a), ek == 3 ? "R6" : "R4", "rsp_data", rsp_data, memword(a));
        if (ek == 3) chk(saw_mem && addr_ok, "R5", "mem_addr", 32'(mem_addr), 32'(a));
        // R8
        else chk(!saw_mem, "R8", "mem_req on hit", 32'(saw_mem), 32'd0);
        @(posedge clk);
        @(negedge clk);
        // R7 R9: pulse ends, kind returns to none
        chk(!rsp_valid && rsp_kind == 2'd0, "R9", "rsp after pulse", 32'(rsp_kind), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NL; i++) begin mv[i] = 1'b0; mt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk(req_ready && !rsp_valid && !mem_req, "R1", "reset outputs",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
        // R1: cold miss, then fast hit (R2)
        access(12'h035, 0);
        access(12'h035, 1);
        // R6: conflicting tag on same home index moves 0x035 to partner
        access(12'h135, 2);
        // R3 R4: partner hit then swap
        access(12'h035, 0);
        access(12'h035, 0);
        access(12'h135, 3);
        // R3: address whose home is 0x035's partner index (index MSB flipped)
        access(12'h03D, 0);
        access(12'h03D, 0);
        // R6: third tag evicts partner
        access(12'h235, 1);
        access(12'h135, 0);
        access(12'h035, 0);
        // R6: refill into empty home index
        access(12'h0A2, 0);
        access(12'h0AA, 0);
        access(12'h0A2, 0);
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] ra;
            ra = {AW'($urandom_range(0, 2))} << IW;
            ra[IW-1:0] = IW'($urandom_range(0, NL - 1));
            access(ra, int'($urandom_range(0, 3)));
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule